// File: doc/BRIEF.md
# Cache Write-Out Data Poisoning Unit

This unit sits between an external cache and the system bus and handles every data word that leaves the cache. A word leaves either because a dirty line is written back to memory or because another requester's snoop hit the line and the cache is sending the data to it. The unit checks the per-byte parity stored with each word. It generates a SEC-DED check code for the bus and passes the word downstream through a single registered stage with a valid/ready handshake.

When the byte parity of a word is wrong, the unit still forwards the data. It corrupts the check code on purpose, so that any receiver decodes the word as a double-bit (uncorrectable) error and never trusts it. The unit also records the first failure in a small sticky status record. Its response to the local processor depends on the transfer type. A failed write-back raises a level error request toward the local processor. A failed snoop reply poisons only the data sent to the requester and leaves the local processor undisturbed, while the record stays available for the requester's error handler to read.

Top module: `cache_wout_poison`

## Requirements
- R1: Byte b of a word is in error when `inParity[b]` differs from the XOR of `inData[8b+7:8b]` (even parity per byte). A word is faulty if any byte is in error.
- R2: A clean word appears on `outData` unchanged. `outEcc[6:0]` is the XOR of the codeword positions of all set data bits, where data bit k occupies the k-th position (counting from 0) in the sequence 3, 5, 6, 7, 9, … that skips powers of two. `outEcc[7]` is the XOR of all data bits and `outEcc[6:0]`.
- R3: A faulty word appears on `outData` unchanged, with `outEcc` equal to the R2 code XOR 8'h03. This poisoning applies to both write-backs and snoop replies.
- R4: `inReady` equals `!outValid || outReady`. A word accepted at a clock edge is presented on the output right after that edge. The output holds stable while `outValid` is high and `outReady` is low, and `outValid` falls after a transfer with no new word accepted.
- R5: A faulty write-back (`inIsWb`=1) sets `errIrq` right after the accepting edge. `errIrq` then stays high until it is cleared.
- R6: A faulty snoop reply (`inIsWb`=0) never raises `errIrq`, but it is recorded in the status like any other failure.
- R7: When a faulty word is accepted and `stsErr` is low, the unit sets `stsErr` and copies `inIsWb` into `stsIsWb` and `inWordIdx` into `stsWordIdx`.
- R8: When a faulty word is accepted while `stsErr` is already set, `stsOvf` is set and `stsIsWb` and `stsWordIdx` keep their values.
- R9: A one-cycle `stsClr` pulse (write-1 to the sticky bit) clears `stsErr`, `stsOvf` and `errIrq`. If a faulty word is accepted in the same cycle, the record is cleared first and the new failure is then captured afresh without overflow.
- R10: After reset, `outValid`, `stsErr`, `stsOvf` and `errIrq` are low, `inReady` is high, and the captured fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Cache word valid |
| inReady | output | 1 | Unit can accept a word |
| inData | input | 64 | Cache word data |
| inParity | input | 8 | Stored even parity, one bit per byte |
| inIsWb | input | 1 | 1 = write-back to memory, 0 = snoop reply |
| inWordIdx | input | 3 | Index of the word within its line |
| outValid | output | 1 | Bus word valid |
| outReady | input | 1 | Bus accepts the word |
| outData | output | 64 | Bus word data |
| outEcc | output | 8 | Bus check code, poisoned on parity fault |
| stsClr | input | 1 | Write-1-to-clear pulse for the sticky record |
| stsErr | output | 1 | Sticky error flag |
| stsIsWb | output | 1 | Type of the captured failure |
| stsWordIdx | output | 3 | Word index of the captured failure |
| stsOvf | output | 1 | A further failure arrived while the record was full |
| errIrq | output | 1 | Disrupting error request to the local processor |

## Verification
Every registered result is due one clock edge after the stimulus that causes it. The output word and check code, `outValid`, the status fields and `errIrq` all change at the edge that accepts or clears. Only `inReady` follows the inputs within the same cycle. The bench drives inputs on the falling edge and checks `inReady` shortly afterwards. It then updates a reference model that stands for the state after the next rising edge, and compares every output against that model on the following falling edge, so each comparison lands in exactly the cycle a result is due. Directed cases cover single flipped parity bits, overflow, clear colliding with a new fault, and stalls, and a long seeded random run then mixes these.

// File: rtl/cwp_pkg.sv
package cwp_pkg;

  // Strobes from control to datapath for one accepted word.
  typedef struct packed {
    logic load;    // capture the incoming word into the output stage
    logic poison;  // corrupt the check code of the captured word
  } cwpStrobe_t;

  // Column mask for Hamming check bit j: data bit k is set when its
  // codeword position (non-power-of-two positions from 3) has bit j set.
  function automatic logic [127:0] hamMask(input int dataW, input int j);
    logic [127:0] m;
    int k;
    m = '0;
    k = 0;
    for (int p = 3; p < 256; p++) begin
      if (((p & (p - 1)) != 0) && (k < dataW)) begin
        if (((p >> j) & 1) == 1) m[k] = 1'b1;
        k++;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/cwp_datapath.sv
module cwp_datapath
  import cwp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 8,
  parameter logic [CHK_W-1:0] POISON = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  cwpStrobe_t        strobe,
  input  logic [DATA_W-1:0] inData,
  input  logic [DATA_W/8-1:0] inParity,
  input  logic              outValid,
  input  logic              outReady,
  output logic              parErr,
  output logic [DATA_W-1:0] outData,
  output logic [CHK_W-1:0]  outEcc
);

  localparam int BYTES = DATA_W / 8;
  localparam int HAM_W = CHK_W - 1;

  logic [BYTES-1:0] byteBad;
  logic [CHK_W-1:0] code;

  // Per-byte even parity check
  for (genvar b = 0; b < BYTES; b++) begin : g_par
    assign byteBad[b] = (^inData[8*b +: 8]) != inParity[b];
  end
  assign parErr = |byteBad;

  // Hamming check bits from constant column masks
  for (genvar j = 0; j < HAM_W; j++) begin : g_ham
    localparam logic [127:0] FULL = hamMask(DATA_W, j);
    localparam logic [DATA_W-1:0] MASK = FULL[DATA_W-1:0];
    assign code[j] = ^(inData & MASK);
  end
  // Overall parity bit for double-error detection
  assign code[CHK_W-1] = ^{inData, code[HAM_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData <= '0;
      outEcc  <= '0;
    end else if (strobe.load) begin
      outData <= inData;
      outEcc  <= code ^ (strobe.poison ? POISON : '0);
    end
  end

  // Clean and poisoned codewords both keep even overall parity (POISON has two bits set)
  p_even_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((^{outData, outEcc}) == 1'b0));

  // Stalled output word must not move
  p_hold_word_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> ($stable(outData) && $stable(outEcc)));

endmodule

// File: rtl/cwp_ctrl.sv
module cwp_ctrl
  import cwp_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inIsWb,
  input  logic [IDX_W-1:0] inWordIdx,
  input  logic             parErr,
  input  logic             outReady,
  input  logic             stsClr,
  output logic             inReady,
  output logic             outValid,
  output cwpStrobe_t       strobe,
  output logic             stsErr,
  output logic             stsIsWb,
  output logic [IDX_W-1:0] stsWordIdx,
  output logic             stsOvf,
  output logic             errIrq
);

  logic fire;
  logic faultIn;
  logic errBase, ovfBase, irqBase;
  logic errNext, ovfNext, irqNext, takeNew;

  assign inReady = !outValid || outReady;
  assign fire    = inValid && inReady;
  assign faultIn = fire && parErr;

  always_comb begin
    strobe        = '0;
    strobe.load   = fire;
    strobe.poison = parErr;
  end

  // Clear applies first, then the new failure is folded in
  always_comb begin
    errBase = stsClr ? 1'b0 : stsErr;
    ovfBase = stsClr ? 1'b0 : stsOvf;
    irqBase = stsClr ? 1'b0 : errIrq;
    takeNew = faultIn && !errBase;
    errNext = errBase || faultIn;
    ovfNext = ovfBase || (faultIn && errBase);
    irqNext = irqBase || (faultIn && inIsWb);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      stsErr     <= 1'b0;
      stsOvf     <= 1'b0;
      stsIsWb    <= 1'b0;
      stsWordIdx <= '0;
      errIrq     <= 1'b0;
    end else begin
      if (fire)          outValid <= 1'b1;
      else if (outReady) outValid <= 1'b0;
      stsErr <= errNext;
      stsOvf <= ovfNext;
      errIrq <= irqNext;
      if (takeNew) begin
        stsIsWb    <= inIsWb;
        stsWordIdx <= inWordIdx;
      end
    end
  end

  p_drain_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !inValid) |=> !outValid);

  p_wb_irq_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && parErr && inIsWb) |=> errIrq);

  p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (errIrq && !stsClr) |=> errIrq);

  p_snoop_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!errIrq && inValid && inReady && parErr && !inIsWb) |=> !errIrq);

  p_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && parErr && (!stsErr || stsClr)) |=>
      (stsErr && !stsOvf && stsWordIdx == $past(inWordIdx) && stsIsWb == $past(inIsWb)));

  p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stsErr && !stsClr && inValid && inReady && parErr) |=>
      (stsOvf && $stable(stsWordIdx) && $stable(stsIsWb)));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stsClr && !(inValid && inReady && parErr)) |=> (!stsErr && !stsOvf && !errIrq));

endmodule

// File: rtl/cache_wout_poison.sv
module cache_wout_poison
  import cwp_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int LINE_WORDS = 8,
  parameter logic [7:0] POISON = 8'h03
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  output logic                       inReady,
  input  logic [DATA_W-1:0]          inData,
  input  logic [DATA_W/8-1:0]        inParity,
  input  logic                       inIsWb,
  input  logic [$clog2(LINE_WORDS)-1:0] inWordIdx,
  output logic                       outValid,
  input  logic                       outReady,
  output logic [DATA_W-1:0]          outData,
  output logic [$clog2(DATA_W)+1:0]  outEcc,
  input  logic                       stsClr,
  output logic                       stsErr,
  output logic                       stsIsWb,
  output logic [$clog2(LINE_WORDS)-1:0] stsWordIdx,
  output logic                       stsOvf,
  output logic                       errIrq
);

  localparam int IDX_W = $clog2(LINE_WORDS);
  localparam int CHK_W = $clog2(DATA_W) + 2;

  cwpStrobe_t strobe;
  logic       parErr;

  cwp_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inIsWb     (inIsWb),
    .inWordIdx  (inWordIdx),
    .parErr     (parErr),
    .outReady   (outReady),
    .stsClr     (stsClr),
    .inReady    (inReady),
    .outValid   (outValid),
    .strobe     (strobe),
    .stsErr     (stsErr),
    .stsIsWb    (stsIsWb),
    .stsWordIdx (stsWordIdx),
    .stsOvf     (stsOvf),
    .errIrq     (errIrq)
  );

  cwp_datapath #(
    .DATA_W (DATA_W),
    .CHK_W  (CHK_W),
    .POISON (POISON[CHK_W-1:0])
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inData   (inData),
    .inParity (inParity),
    .outValid (outValid),
    .outReady (outReady),
    .parErr   (parErr),
    .outData  (outData),
    .outEcc   (outEcc)
  );

endmodule

// File: tb/cache_wout_poison_bench.sv
module cache_wout_poison_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [63:0] inData = '0;
  logic [7:0]  inParity = '0;
  logic        inIsWb = 1'b0;
  logic [2:0]  inWordIdx = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [63:0] outData;
  logic [7:0]  outEcc;
  logic        stsClr = 1'b0;
  logic        stsErr, stsIsWb, stsOvf, errIrq;
  logic [2:0]  stsWordIdx;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Reference model state (state after the next rising edge)
  logic        mOutValid = 1'b0;
  logic [63:0] mOutData = '0;
  logic [7:0]  mOutEcc = '0;
  logic        mPois = 1'b0;
  logic        mErr = 1'b0, mIsWb = 1'b0, mOvf = 1'b0, mIrq = 1'b0;
  logic [2:0]  mIdx = '0;

  always #4 clk = ~clk;  // 125 MHz

  cache_wout_poison u_cache_wout_poison (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inParity(inParity), .inIsWb(inIsWb), .inWordIdx(inWordIdx),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outEcc(outEcc),
    .stsClr(stsClr), .stsErr(stsErr), .stsIsWb(stsIsWb), .stsWordIdx(stsWordIdx),
    .stsOvf(stsOvf), .errIrq(errIrq)
  );

  function automatic logic [7:0] goodPar(input logic [63:0] d);
    logic [7:0] p;
    for (int b = 0; b < 8; b++) p[b] = ^d[8*b +: 8];
    return p;
  endfunction

  // Syndrome-style reference: XOR of positions of set data bits
  function automatic logic [7:0] refEcc(input logic [63:0] d);
    logic [6:0] s;
    int p;
    s = '0;
    p = 2;
    for (int k = 0; k < 64; k++) begin
      p++;
      if ((p & (p - 1)) == 0) p++;
      if (d[k]) s ^= p[6:0];
    end
    return {^{d, s}, s};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R4 outValid", {63'd0, outValid}, {63'd0, mOutValid});
    if (mOutValid) begin
      chk("R2 outData", outData, mOutData);
      chk(mPois ? "R3 outEcc poisoned" : "R2 outEcc", {56'd0, outEcc}, {56'd0, mOutEcc});
    end
    chk("R7 stsErr", {63'd0, stsErr}, {63'd0, mErr});
    chk("R7 stsIsWb", {63'd0, stsIsWb}, {63'd0, mIsWb});
    chk("R7 stsWordIdx", {61'd0, stsWordIdx}, {61'd0, mIdx});
    chk("R8 stsOvf", {63'd0, stsOvf}, {63'd0, mOvf});
    chk("R5 errIrq", {63'd0, errIrq}, {63'd0, mIrq});
  endtask

  // Called at a falling edge: drive, check ready, model one edge, compare
  task automatic step(input logic v, input logic [63:0] d, input logic [7:0] p,
                      input logic wb, input logic [2:0] idx, input logic rdy, input logic clr);
    logic fire, perr, eB, oB, iB;
    inValid = v; inData = d; inParity = p; inIsWb = wb; inWordIdx = idx;
    outReady = rdy; stsClr = clr;
    #1;
    chk("R4 inReady", {63'd0, inReady}, {63'd0, (!mOutValid || rdy)});
    fire = v && (!mOutValid || rdy);
    perr = (p != goodPar(d));
    if (fire) begin
      mOutValid = 1'b1; mOutData = d; mPois = perr;
      mOutEcc = refEcc(d) ^ (perr ? 8'h03 : 8'h00);
    end else if (rdy) mOutValid = 1'b0;
    eB = clr ? 1'b0 : mErr; oB = clr ? 1'b0 : mOvf; iB = clr ? 1'b0 : mIrq;
    if (fire && perr && !eB) begin mIsWb = wb; mIdx = idx; end
    mOvf = oB || (fire && perr && eB);
    mErr = eB || (fire && perr);
    mIrq = iB || (fire && perr && wb);
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 outValid", {63'd0, outValid}, 64'd0);
    chk("R10 inReady", {63'd0, inReady}, 64'd1);
    chk("R10 stsErr", {63'd0, stsErr}, 64'd0);
    chk("R10 stsOvf", {63'd0, stsOvf}, 64'd0);
    chk("R10 errIrq", {63'd0, errIrq}, 64'd0);
    chk("R10 stsWordIdx", {61'd0, stsWordIdx}, 64'd0);

    // R2 clean words
    d = 64'h0123_4567_89AB_CDEF;
    step(1, d, goodPar(d), 1, 3'd1, 1, 0);
    step(1, 64'h1, goodPar(64'h1), 0, 3'd2, 1, 0);
    step(1, '1, goodPar('1), 1, 3'd3, 1, 0);

    // R1 single flipped parity bit on top byte, snoop reply: poisoned, no interrupt (R6)
    d = 64'hFEDC_BA98_7654_3210;
    step(1, d, goodPar(d) ^ 8'h80, 0, 3'd5, 1, 0);
    chk("R6 errIrq low after snoop fault", {63'd0, errIrq}, 64'd0);
    chk("R1 outEcc poisoned", {56'd0, outEcc}, {56'd0, refEcc(d) ^ 8'h03});
    // R8 write-back fault while record full: overflow, irq, details kept
    step(1, d, goodPar(d) ^ 8'h01, 1, 3'd6, 1, 0);
    chk("R8 stsWordIdx kept", {61'd0, stsWordIdx}, 64'd5);
    // R9 clear
    step(0, '0, '0, 0, 3'd0, 1, 1);
    chk("R9 cleared", {61'd0, stsErr, stsOvf, errIrq}, 64'd0);
    // R5 write-back fault then R9 clear colliding with a new snoop fault
    step(1, d, goodPar(d) ^ 8'h10, 1, 3'd7, 1, 0);
    step(1, d, goodPar(d) ^ 8'h04, 0, 3'd2, 1, 1);
    chk("R9 fresh capture idx", {61'd0, stsWordIdx}, 64'd2);
    chk("R9 fresh capture irq", {63'd0, errIrq}, 64'd0);
    // R4 stall and drain
    step(1, 64'hAAAA_5555_0F0F_F0F0, goodPar(64'hAAAA_5555_0F0F_F0F0), 1, 3'd0, 0, 1);
    step(1, 64'h5, goodPar(64'h5), 1, 3'd1, 0, 0);
    step(1, 64'h5, goodPar(64'h5), 1, 3'd1, 0, 0);
    step(0, '0, '0, 0, 3'd0, 1, 0);
    step(0, '0, '0, 0, 3'd0, 1, 0);

    // Seeded random mix
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] rd;
      logic [7:0]  rp;
      rd = {$urandom, $urandom};
      rp = goodPar(rd);
      if ($urandom_range(7) == 0) rp ^= 8'(1 << $urandom_range(7));
      step(($urandom_range(3) != 0), rd, rp, 1'($urandom_range(1)), 3'($urandom_range(7)),
           ($urandom_range(3) != 0), ($urandom_range(19) == 0));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule